// File: doc/BRIEF.md
# Ping-Pong Context Staging Buffer

This block sits in front of a processing engine and gives it two equal memory banks that trade roles. One bank is active: the engine reads and writes the current packet's key, running state and payload there. The other bank is the shadow: a loader fills it with everything the next packet needs. Each bank is one flat word space, so key, state and data for a packet are staged together and switch together.

When the engine signals that it is finished and the shadow bank is complete, the roles swap at that clock edge. The engine then works on the new context without a gap, and the bank it just left becomes the loader's next target. If the engine finishes before the shadow bank is complete, the engine is left without a context until the load-done strobe arrives, and the swap happens at that same edge. Loader writes are refused while the shadow bank holds a complete context. A load-done strobe at that time is reported as an overrun and otherwise ignored.

Top module: `ctx_pingpong`

## Requirements
- R1: After reset, `act_bank` is 1 (bank 0 is the shadow bank), and `shd_ready`, `ctx_valid` and `ld_overrun` are all 0.
- R2: A loader write (`ld_we`) stores `ld_wdata` at `ld_addr` in the bank whose index differs from `act_bank`. The engine port reads the bank given by `act_bank`. `eng_rdata` shows the word at the `eng_addr` presented in one cycle after the next rising edge.
- R3: A `ld_done` pulse while `ctx_valid` is 1, `shd_ready` is 0 and `eng_done` is low sets `shd_ready` to 1 at that edge and leaves `act_bank` unchanged.
- R4: A `ld_done` pulse while `ctx_valid` is 0 and `shd_ready` is 0 swaps the banks at that same edge: `act_bank` toggles, `ctx_valid` becomes 1 and `shd_ready` stays 0.
- R5: An `eng_done` pulse while `ctx_valid` and `shd_ready` are both 1 swaps the banks at that edge: `act_bank` toggles, `ctx_valid` stays 1 and `shd_ready` becomes 0.
- R6: An `eng_done` pulse while `ctx_valid` is 1 and `shd_ready` is 0 (with no `ld_done`) clears `ctx_valid` at that edge and leaves `act_bank` unchanged, so the engine stalls until the load finishes.
- R7: After a swap, the bank that was just released is the one that the next loader writes fill, and the engine reads that data after the following swap.
- R8: Loader writes while `shd_ready` is 1 are dropped, and the staged context is left unchanged.
- R9: A `ld_done` pulse while `shd_ready` is 1 raises `ld_overrun` for exactly the next cycle and changes neither `act_bank` nor `shd_ready`. In all other cycles `ld_overrun` is 0.
- R10: An engine write (`eng_we`) stores `eng_wdata` at `eng_addr` in the active bank. A read of the same address in the same cycle returns the old word.
- R11: An `eng_done` pulse while `ctx_valid` is 0 and no load completes changes none of `act_bank`, `ctx_valid` or `shd_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Loader write enable (targets the shadow bank) |
| ld_addr | input | ADDR_W | Loader word address |
| ld_wdata | input | DATA_W | Loader write data |
| ld_done | input | 1 | Loader strobe: shadow bank fully staged |
| eng_we | input | 1 | Engine write enable (targets the active bank) |
| eng_addr | input | ADDR_W | Engine read/write address |
| eng_wdata | input | DATA_W | Engine write data |
| eng_done | input | 1 | Engine strobe: active context finished |
| eng_rdata | output | DATA_W | Engine read data, one cycle after the address |
| act_bank | output | 1 | Index of the active bank |
| shd_ready | output | 1 | Shadow bank holds a complete context |
| ctx_valid | output | 1 | Active bank holds a context the engine may run |
| ld_overrun | output | 1 | One-cycle flag: load-done while shadow already full |

## Verification
The bench targets the ordering corners of the swap. In one case the engine finishes first and then the load completes. A design that swaps one cycle late, or only on `eng_done`, would leave the engine stalled forever or show the old `act_bank`. In the other case the load completes first and the engine finishes later. A design that swaps early would corrupt a running context. The bench reads back every staged word after each swap, which exposes steering to the wrong bank or a released bank that is not reused. It also issues writes and a second load-done against a full shadow bank, where a broken lock overwrites staged words or misses the overrun pulse. A same-cycle engine write and read checks that the old word is returned, and an idle `eng_done` checks that no spurious swap occurs.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int unsigned BANK_CNT = 2;

  typedef logic bank_t;

  function automatic bank_t peer_bank(bank_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/ctx_bank.sv
// One context bank: single write port, registered read port (read-first).
module ctx_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctx_role_ctrl.sv
// Tracks which bank is active, whether the shadow is staged, and swaps roles.
module ctx_role_ctrl (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_done,
  input  logic          eng_done,
  output ctx_pkg::bank_t act_sel,
  output logic          shd_full,
  output logic          ctx_valid,
  output logic          overrun
);
  logic ld_take;
  logic ready_now;
  logic swap;

  always_comb begin
    ld_take   = ld_done && !shd_full;
    ready_now = shd_full || ld_take;
    swap      = ready_now && (!ctx_valid || eng_done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel   <= 1'b1;
      shd_full  <= 1'b0;
      ctx_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      overrun <= ld_done && shd_full;
      if (swap) begin
        act_sel   <= ctx_pkg::peer_bank(act_sel);
        ctx_valid <= 1'b1;
        shd_full  <= 1'b0;
      end else begin
        shd_full <= ready_now;
        if (eng_done) begin
          ctx_valid <= 1'b0;
        end
      end
    end
  end

  AST_SWAP_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (ctx_valid && eng_done && shd_full) |=> (act_sel != $past(act_sel)) && ctx_valid && !shd_full); // R5

  AST_SWAP_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!ctx_valid && ld_done && !shd_full) |=> (act_sel != $past(act_sel)) && ctx_valid); // R4

  AST_STALL_WAIT: assert property (@(posedge clk) disable iff (rst)
    (ctx_valid && eng_done && !shd_full && !ld_done) |=> !ctx_valid && $stable(act_sel)); // R6

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ctx_valid && !eng_done) |=> $stable(act_sel) && ctx_valid); // R3

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (ld_done && shd_full) |=> overrun); // R9

  AST_OVERRUN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(ld_done && shd_full) |=> !overrun); // R9
endmodule

// File: rtl/ctx_wr_steer.sv
// Routes loader writes to the shadow bank and engine writes to the active bank.
module ctx_wr_steer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  ctx_pkg::bank_t    act_sel,
  input  logic              shd_full,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_wdata,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic              bank_we    [ctx_pkg::BANK_CNT],
  output logic [ADDR_W-1:0] bank_waddr [ctx_pkg::BANK_CNT],
  output logic [DATA_W-1:0] bank_wdata [ctx_pkg::BANK_CNT]
);
  for (genvar g = 0; g < ctx_pkg::BANK_CNT; g++) begin : g_route
    localparam ctx_pkg::bank_t MY_ID = (g == 1) ? 1'b1 : 1'b0;
    logic ld_hit;
    logic eng_hit;

    always_comb begin
      ld_hit  = ld_we && !shd_full && (ctx_pkg::peer_bank(act_sel) == MY_ID);
      eng_hit = eng_we && (act_sel == MY_ID);
      bank_we[g]    = ld_hit || eng_hit;
      bank_waddr[g] = eng_hit ? eng_addr  : ld_addr;
      bank_wdata[g] = eng_hit ? eng_wdata : ld_wdata;
    end
  end
endmodule

// File: rtl/ctx_pingpong.sv
module ctx_pingpong #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_wdata,
  input  logic              ld_done,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_done,
  output logic [DATA_W-1:0] eng_rdata,
  output logic              act_bank,
  output logic              shd_ready,
  output logic              ctx_valid,
  output logic              ld_overrun
);
  localparam int unsigned NB = ctx_pkg::BANK_CNT;

  ctx_pkg::bank_t    act_sel;
  ctx_pkg::bank_t    rd_sel_q;
  logic              shd_full;
  logic              bank_we    [NB];
  logic [ADDR_W-1:0] bank_waddr [NB];
  logic [DATA_W-1:0] bank_wdata [NB];
  logic [DATA_W-1:0] bank_rdata [NB];

  ctx_role_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ld_done   (ld_done),
    .eng_done  (eng_done),
    .act_sel   (act_sel),
    .shd_full  (shd_full),
    .ctx_valid (ctx_valid),
    .overrun   (ld_overrun)
  );

  ctx_wr_steer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_steer (
    .act_sel    (act_sel),
    .shd_full   (shd_full),
    .ld_we      (ld_we),
    .ld_addr    (ld_addr),
    .ld_wdata   (ld_wdata),
    .eng_we     (eng_we),
    .eng_addr   (eng_addr),
    .eng_wdata  (eng_wdata),
    .bank_we    (bank_we),
    .bank_waddr (bank_waddr),
    .bank_wdata (bank_wdata)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    ctx_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
      .clk   (clk),
      .we    (bank_we[g]),
      .waddr (bank_waddr[g]),
      .wdata (bank_wdata[g]),
      .raddr (eng_addr),
      .rdata (bank_rdata[g])
    );
  end

  // The read returns data from the bank that was active when the address was presented.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q <= 1'b1;
    end else begin
      rd_sel_q <= act_sel;
    end
  end

  always_comb begin
    eng_rdata = bank_rdata[rd_sel_q];
    act_bank  = act_sel;
    shd_ready = shd_full;
  end

  AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (shd_full && !eng_we) |-> !bank_we[0] && !bank_we[1]); // R8
endmodule

// File: tb/test_ctx_pingpong.sv
module test_ctx_pingpong;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned NVEC   = 6;
  // Each entry: bit 16 = engine finishes before the load, bits 15:0 = data seed.
  localparam logic [16:0] VEC_TAB [NVEC] = '{
    17'h0_1234, 17'h0_a5a5, 17'h1_0f0f, 17'h0_7e81, 17'h1_c3c3, 17'h1_5aa5
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_we = 1'b0, ld_done = 1'b0, eng_we = 1'b0, eng_done = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0, eng_addr = '0;
  logic [DATA_W-1:0] ld_wdata = '0, eng_wdata = '0;
  logic [DATA_W-1:0] eng_rdata;
  logic act_bank, shd_ready, ctx_valid, ld_overrun;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;
  logic exp_act = 1'b1;

  always #2 clk = ~clk;

  ctx_pingpong #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctx_pingpong (
    .clk(clk), .rst(rst),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_wdata(ld_wdata), .ld_done(ld_done),
    .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_done(eng_done),
    .eng_rdata(eng_rdata), .act_bank(act_bank), .shd_ready(shd_ready),
    .ctx_valid(ctx_valid), .ld_overrun(ld_overrun)
  );

  function automatic logic [DATA_W-1:0] pat(input logic [15:0] seed, input int a);
    return {seed, (16'(a) * 16'h0101) ^ ~seed};
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic a, input logic s, input logic v);
    chk({req, " act_bank"}, 32'(act_bank), 32'(a));
    chk({req, " shd_ready"}, 32'(shd_ready), 32'(s));
    chk({req, " ctx_valid"}, 32'(ctx_valid), 32'(v));
  endtask

  task automatic load_pkt(input logic [15:0] seed);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = ADDR_W'(a); ld_wdata = pat(seed, a);
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic pulse_ld_done();
    @(negedge clk); ld_done = 1'b1;
    @(negedge clk); ld_done = 1'b0;
  endtask

  task automatic pulse_eng_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic eng_read(input int a, output logic [DATA_W-1:0] d);
    @(negedge clk); eng_addr = ADDR_W'(a);
    @(negedge clk); d = eng_rdata;
  endtask

  task automatic verify_bank(input string req, input logic [15:0] seed);
    logic [DATA_W-1:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      eng_read(a, d);
      chk(req, d, pat(seed, a));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_state("R1", 1'b1, 1'b0, 1'b0);
    chk("R1 ld_overrun", 32'(ld_overrun), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] seed = VEC_TAB[i][15:0];
      logic early = VEC_TAB[i][16];
      if (!ctx_valid) begin
        load_pkt(seed);
        pulse_ld_done();
        exp_act = ~exp_act;
        chk_state("R4 swap on load while idle", exp_act, 1'b0, 1'b1);
      end else if (early) begin
        pulse_eng_done();
        chk_state("R6 stall without staged context", exp_act, 1'b0, 1'b0);
        load_pkt(seed);
        pulse_ld_done();
        exp_act = ~exp_act;
        chk_state("R6 swap in load-done cycle", exp_act, 1'b0, 1'b1);
      end else begin
        load_pkt(seed);
        pulse_ld_done();
        chk_state("R3 shadow staged", exp_act, 1'b1, 1'b1);
        pulse_eng_done();
        exp_act = ~exp_act;
        chk_state("R5 single-cycle swap", exp_act, 1'b0, 1'b1);
      end
      // R2 / R7: staged words visible in the new active bank
      verify_bank(i == 0 ? "R2 shadow write then read" : "R7 released bank reloaded", seed);
      // R10 engine write, read-first on the same cycle
      @(negedge clk);
      eng_we = 1'b1; eng_addr = ADDR_W'(3); eng_wdata = ~pat(seed, 3);
      @(negedge clk);
      eng_we = 1'b0;
      chk("R10 read-first", eng_rdata, pat(seed, 3));
      eng_read(3, d);
      chk("R10 engine write", d, ~pat(seed, 3));
    end

    // R8 / R9: full shadow refuses writes, second load-done flagged
    load_pkt(16'hbeef);
    pulse_ld_done();
    chk_state("R3 staged before overrun", exp_act, 1'b1, 1'b1);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = ADDR_W'(5); ld_wdata = 32'hdead_0005;
    @(negedge clk);
    ld_we = 1'b0;
    chk("R9 no flag without load-done", 32'(ld_overrun), 32'd0);
    pulse_ld_done();
    chk("R9 overrun pulse", 32'(ld_overrun), 32'd1);
    chk_state("R9 state kept", exp_act, 1'b1, 1'b1);
    @(negedge clk);
    chk("R9 overrun one cycle", 32'(ld_overrun), 32'd0);
    pulse_eng_done();
    exp_act = ~exp_act;
    chk_state("R5 swap after overrun", exp_act, 1'b0, 1'b1);
    eng_read(5, d);
    chk("R8 blocked write", d, pat(16'hbeef, 5));
    eng_read(6, d);
    chk("R8 staged word intact", d, pat(16'hbeef, 6));

    // R11: done while idle is ignored
    pulse_eng_done();
    chk_state("R6 engine idle", exp_act, 1'b0, 1'b0);
    pulse_eng_done();
    chk_state("R11 idle done ignored", exp_act, 1'b0, 1'b0);
    load_pkt(16'h4242);
    pulse_ld_done();
    exp_act = ~exp_act;
    chk_state("R4 swap after idle done", exp_act, 1'b0, 1'b1);
    eng_read(9, d);
    chk("R7 data after idle", d, pat(16'h4242, 9));

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_state("R1 after second reset", 1'b1, 1'b0, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule